// File: doc/BRIEF.md
# Windowed Clock Frequency Meter

This unit estimates the frequency of a modulated clock by counting its rising edges inside a gate window that opens at a programmable distance after each modulation-period start strobe. All timing is taken from a reference clock. The gate offset and the gate length are both given in units of 256 reference cycles. The asynchronous measured clock crosses into the reference domain through a two-stage synchronizer with rising-edge detection. Each detected edge adds one to the count of the current window.

Window counts can be summed over 2^n consecutive modulation periods, with n from 0 to 7. When the last window of a group closes, the sum is placed on the result bus and a done flag pulses. An optional dead-clock mode forces the result to zero when any window of the group saw no edges. The unit runs only while its enable is high. A strobe that arrives before the window it interrupts has closed aborts the group and raises an error flag. A combinational check flags a gate placement that does not end before 95 % of the modulation period.

The controller is a four-state machine:
- **IDLE**: disabled, or enabled but no strobe seen yet. A strobe moves it to DELAY, or straight to GATE when the offset is zero.
- **DELAY**: counts unit ticks until the offset has elapsed, then moves to GATE.
- **GATE**: counts edges until the length has elapsed, then moves to HOLD.
- **HOLD**: waits for the next strobe and then re-enters DELAY or GATE.

A strobe seen in DELAY or GATE is an early restart. Clearing the enable forces IDLE from any state.

Top module: `freq_window_meter`

## Requirements
- R1: After reset, result_o is 0, done_o is 0, error_o is 0 and the controller is in IDLE.
- R2: Taking a strobe sampled at edge k, edges sampled at edges k+256·S+1 through k+256·(S+L) are counted. S is the offset field and L the length field. With a measured clock of exactly 4 reference periods, one window therefore counts 64·L edges, and edges that occur only during the offset are not counted.
- R3: With periods_log2_i = n, the window counts of 2^n consecutive periods are summed. done_o is high for exactly one reference cycle, at the close of the last window of the group, and this holds for n = 0 up to n = 7 (128 periods).
- R4: result_o changes only together with a done_o pulse and otherwise holds its value.
- R5: With dead_zero_i = 1, a group in which any window counted zero edges reports 0. With dead_zero_i = 0, the same group reports the plain sum.
- R6: A strobe in DELAY or GATE discards the partial group and sets error_o. It produces no done_o for the aborted group and starts a fresh group from that strobe. error_o stays set while enable_i stays high.
- R7: While enable_i is low, strobes are ignored, done_o stays 0, error_o is cleared, and the partial sum and the period index are cleared. The first strobe after re-enabling starts a fresh group.
- R8: cfg_bad_o is 1 when 20·(S+L) ≥ 19·P, where P is period_units_i, or when L = 0. It is 0 otherwise.
- R9: S and L are captured at every strobe, and n and dead_zero_i at the first strobe of a group. A change during a window takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Unit enable; low forces IDLE |
| meas_clk_i | input | 1 | Asynchronous clock being measured |
| period_start_i | input | 1 | One-cycle strobe at each modulation-period start |
| start_units_i | input | 12 | Gate offset S, in 256-cycle units |
| len_units_i | input | 12 | Gate length L, in 256-cycle units |
| period_units_i | input | 16 | Modulation period P, in 256-cycle units (placement check only) |
| periods_log2_i | input | 3 | n: the group covers 2^n periods |
| dead_zero_i | input | 1 | Dead-clock mode enable |
| result_o | output | 32 | Summed edge count of the last completed group |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| error_o | output | 1 | Sticky flag for an early strobe |
| cfg_bad_o | output | 1 | Gate placement violates the 95 % rule or L = 0 |

## Verification
The bench drives measured clocks at 4 and 8 reference periods, so every window count is exact and offsets, lengths and group sizes give distinct sums. A clock that stops after the offset has begun separates a honoured offset from a window that opens early. A clock that dies in the second period of a two-period group separates the dead-clock mode from the plain sum. Early strobes, disable during a group, and a length change inside a window show that partial state is discarded and that fields are captured at the right moment.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_GATE  = 2'd2,
        ST_HOLD  = 2'd3
    } fwm_state_e;

endpackage

// File: rtl/fwm_edge_sync.sv
module fwm_edge_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);

    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise_o = s2_q & ~s3_q;

    // R2: a detected rising edge never spans two reference cycles
    p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fwm_unit_timer.sv
module fwm_unit_timer #(
    parameter int UNIT_LOG2 = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);

    logic [UNIT_LOG2-1:0] pre_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             pre_q <= '0;
        else if (restart_i || !run_i) pre_q <= '0;
        else                     pre_q <= pre_q + 1'b1;
    end

    assign tick_o = run_i & (&pre_q);

    // R2: unit ticks are isolated single-cycle events
    p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/fwm_cfg_check.sv
module fwm_cfg_check #(
    parameter int UC_W  = 12,
    parameter int PER_W = 16
) (
    input  logic [UC_W-1:0]  start_i,
    input  logic [UC_W-1:0]  len_i,
    input  logic [PER_W-1:0] period_i,
    output logic             bad_o
);

    localparam int SUM_W = UC_W + 1;
    localparam int CMP_W = ((SUM_W > PER_W) ? SUM_W : PER_W) + 5;

    logic [CMP_W-1:0] lhs, rhs;

    always_comb begin
        lhs   = CMP_W'({1'b0, start_i} + {1'b0, len_i}) * CMP_W'(20);
        rhs   = CMP_W'(period_i) * CMP_W'(19);
        bad_o = (lhs >= rhs) || (len_i == '0);
    end

endmodule

// File: rtl/freq_window_meter.sv
module freq_window_meter
    import fwm_pkg::*;
#(
    parameter int UC_W      = 12,
    parameter int PER_W     = 16,
    parameter int N_W       = 3,
    parameter int ACC_W     = 32,
    parameter int UNIT_LOG2 = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             meas_clk_i,
    input  logic             period_start_i,
    input  logic [UC_W-1:0]  start_units_i,
    input  logic [UC_W-1:0]  len_units_i,
    input  logic [PER_W-1:0] period_units_i,
    input  logic [N_W-1:0]   periods_log2_i,
    input  logic             dead_zero_i,
    output logic [ACC_W-1:0] result_o,
    output logic             done_o,
    output logic             error_o,
    output logic             cfg_bad_o
);

    localparam int PIDX_W = (1 << N_W) - 1;

    fwm_state_e st_q, st_d;

    logic              rise, tick, strobe;
    logic [UC_W-1:0]   units_q, start_q, len_q;
    logic [N_W-1:0]    nlog_q;
    logic              dead_q, dead_seen_q;
    logic [PIDX_W-1:0] pidx_q;
    logic [PIDX_W:0]   grp_size;
    logic [ACC_W-1:0]  cnt_q, acc_q, win_total;
    logic              delay_done, gate_done, grp_last, win_empty, busy;

    fwm_edge_sync u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (meas_clk_i),
        .rise_o  (rise)
    );

    assign strobe = enable_i & period_start_i;

    fwm_unit_timer #(.UNIT_LOG2(UNIT_LOG2)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (enable_i),
        .restart_i (strobe),
        .tick_o    (tick)
    );

    fwm_cfg_check #(.UC_W(UC_W), .PER_W(PER_W)) u_cfg (
        .start_i  (start_units_i),
        .len_i    (len_units_i),
        .period_i (period_units_i),
        .bad_o    (cfg_bad_o)
    );

    assign busy       = (st_q == ST_DELAY) || (st_q == ST_GATE);
    assign delay_done = tick && ((units_q + 1'b1) >= start_q);
    assign gate_done  = tick && ((units_q + 1'b1) >= len_q);
    assign grp_size   = (PIDX_W+1)'(1) << nlog_q;
    assign grp_last   = ({1'b0, pidx_q} == (grp_size - 1'b1));
    assign win_total  = cnt_q + ACC_W'(rise);
    assign win_empty  = (win_total == '0);

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d = ST_IDLE;
        end else if (strobe) begin
            st_d = (start_units_i == '0) ? ST_GATE : ST_DELAY;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_DELAY: if (delay_done) st_d = ST_GATE;
                ST_GATE:  if (gate_done)  st_d = ST_HOLD;
                ST_HOLD:  st_d = ST_HOLD;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_IDLE;
        else         st_q <= st_d;
    end

    // datapath and outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            units_q     <= '0;
            start_q     <= '0;
            len_q       <= '0;
            nlog_q      <= '0;
            dead_q      <= 1'b0;
            dead_seen_q <= 1'b0;
            pidx_q      <= '0;
            cnt_q       <= '0;
            acc_q       <= '0;
            result_o    <= '0;
            done_o      <= 1'b0;
            error_o     <= 1'b0;
        end else if (!enable_i) begin
            units_q     <= '0;
            cnt_q       <= '0;
            acc_q       <= '0;
            pidx_q      <= '0;
            dead_seen_q <= 1'b0;
            done_o      <= 1'b0;
            error_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (strobe) begin
                units_q <= '0;
                cnt_q   <= '0;
                start_q <= start_units_i;
                len_q   <= len_units_i;
                if (busy) begin
                    error_o     <= 1'b1;
                    acc_q       <= '0;
                    pidx_q      <= '0;
                    dead_seen_q <= 1'b0;
                    nlog_q      <= periods_log2_i;
                    dead_q      <= dead_zero_i;
                end else if (pidx_q == '0) begin
                    nlog_q <= periods_log2_i;
                    dead_q <= dead_zero_i;
                end
            end else begin
                unique case (st_q)
                    ST_DELAY: begin
                        if (tick) units_q <= delay_done ? '0 : units_q + 1'b1;
                    end
                    ST_GATE: begin
                        cnt_q <= win_total;
                        if (tick) units_q <= units_q + 1'b1;
                        if (gate_done) begin
                            if (grp_last) begin
                                result_o    <= (dead_q && (dead_seen_q || win_empty))
                                               ? '0 : acc_q + win_total;
                                done_o      <= 1'b1;
                                acc_q       <= '0;
                                pidx_q      <= '0;
                                dead_seen_q <= 1'b0;
                            end else begin
                                acc_q       <= acc_q + win_total;
                                pidx_q      <= pidx_q + 1'b1;
                                dead_seen_q <= dead_seen_q | win_empty;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: completion is a single-cycle pulse
    p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R4: the result bus moves only with a completion pulse
    p_result_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

    // R6: the early-strobe flag stays set while enabled
    p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && error_o) |=> error_o);

    // R7: a disabled unit neither completes nor keeps an error
    p_quiet_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!done_o && !error_o));

    // R6: an early strobe always lands in a measurement state afterwards
    p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe |=> (st_q == ST_DELAY || st_q == ST_GATE));

endmodule

// File: tb/test_freq_window_meter.sv
`timescale 1ns/1ps
module test_freq_window_meter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        mclk = 1'b0;
    logic        ps = 1'b0;
    logic [11:0] s_u = 12'd1;
    logic [11:0] l_u = 12'd2;
    logic [15:0] p_u = 16'd4;
    logic [2:0]  nlog = 3'd0;
    logic        dz = 1'b0;
    logic [31:0] res;
    logic        done, err, bad;

    int  checks = 0;
    int  errors = 0;
    int  meas_half = 40;
    bit  meas_run = 1'b1;

    int unsigned exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    always begin
        #(meas_half);
        if (meas_run) mclk = ~mclk;
        else          mclk = 1'b0;
    end

    freq_window_meter i_freq_window_meter (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .enable_i       (en),
        .meas_clk_i     (mclk),
        .period_start_i (ps),
        .start_units_i  (s_u),
        .len_units_i    (l_u),
        .period_units_i (p_u),
        .periods_log2_i (nlog),
        .dead_zero_i    (dz),
        .result_o       (res),
        .done_o         (done),
        .error_o        (err),
        .cfg_bad_o      (bad)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL unexpected done actual=%0d expected=none", res);
            end else begin
                automatic int unsigned e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, res, e);
            end
        end
    end

    task automatic expect_res(input string tag, input int unsigned v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk) ps = 1'b1;
        @(negedge clk) ps = 1'b0;
    endtask

    task automatic period(input int units);
        strobe();
        cyc(units * 256 - 1);
    endtask

    task automatic restart();
        @(negedge clk) en = 1'b0;
        cyc(4);
        en = 1'b1;
        cyc(2);
    endtask

    initial begin
        #(190000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        cyc(3);
        // R1: reset state
        chk("R1 result", res, 0);
        chk("R1 done", done, 0);
        chk("R1 error", err, 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 result after release", res, 0);
        chk("R8 legal placement", bad, 0);
        en = 1'b1;
        cyc(2);

        // R2 / R9: S=1 L=2, clock of 4 ref periods -> 128; length change mid-window
        expect_res("R2 single window", 128);
        strobe();
        cyc(100);
        l_u = 12'd3;
        cyc(4 * 256 - 101);
        expect_res("R9 new length from next period", 192);
        period(5);
        restart();

        // R3: four periods of L=1 at 8 ref periods per edge -> 4*32
        meas_half = 80;
        s_u = 12'd0; l_u = 12'd1; nlog = 3'd2;
        cyc(20);
        expect_res("R3 four-period sum", 128);
        repeat (4) period(2);
        strobe();
        cyc(300);
        chk("R4 result held during next group", res, 128);
        restart();

        // R3: maximum group of 128 periods -> 128*64
        meas_half = 40;
        nlog = 3'd7;
        cyc(20);
        expect_res("R3 128-period sum", 8192);
        repeat (128) period(2);
        restart();

        // R2: edges only during the offset are not counted
        nlog = 3'd0; s_u = 12'd2; l_u = 12'd1;
        expect_res("R2 offset honoured", 0);
        strobe();
        cyc(300);
        meas_run = 1'b0;
        cyc(4 * 256 - 301);
        meas_run = 1'b1;
        restart();

        // R5: dead-clock mode on, second window dead -> 0
        nlog = 3'd1; s_u = 12'd1; l_u = 12'd1; dz = 1'b1;
        cyc(20);
        expect_res("R5 dead mode zero", 0);
        period(3);
        meas_run = 1'b0;
        period(3);
        restart();
        // R5: dead-clock mode off, same pattern -> first window only
        meas_run = 1'b1; dz = 1'b0;
        cyc(20);
        expect_res("R5 plain sum", 64);
        period(3);
        meas_run = 1'b0;
        period(3);
        meas_run = 1'b1;
        restart();

        // R6: early strobe inside the window
        nlog = 3'd0; s_u = 12'd1; l_u = 12'd2;
        cyc(20);
        strobe();
        cyc(512);
        expect_res("R6 fresh group after abort", 128);
        strobe();
        cyc(1);
        chk("R6 error raised", err, 1);
        cyc(4 * 256);
        chk("R6 error sticky", err, 1);
        chk("R6 abort produced no extra result", exp_q.size(), 0);

        // R7: disable clears error and partial sum
        @(negedge clk) en = 1'b0;
        cyc(2);
        chk("R7 error cleared", err, 0);
        strobe();
        cyc(10);
        chk("R7 strobe ignored while off", done, 0);
        en = 1'b1;
        nlog = 3'd1; s_u = 12'd0; l_u = 12'd1;
        cyc(4);
        period(2);
        @(negedge clk) en = 1'b0;
        cyc(4);
        en = 1'b1;
        cyc(2);
        expect_res("R7 partial sum discarded", 128);
        period(2);
        period(2);
        chk("R7 all results produced", exp_q.size(), 0);

        // R8: placement check
        @(negedge clk) begin s_u = 12'd2; l_u = 12'd3; p_u = 16'd5; end
        cyc(1);
        chk("R8 too late", bad, 1);
        p_u = 16'd6;
        cyc(1);
        chk("R8 fits", bad, 0);
        l_u = 12'd0;
        cyc(1);
        chk("R8 zero length", bad, 1);

        cyc(10);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        summary();
    end

endmodule